// File: doc/BRIEF.md
# Single-Error-Correcting Memory Word Controller

This block sits between a processor memory port and a memory array that stores 21-bit words. Every write carries a 16-bit data word. The block packs that word into a 21-bit Hamming codeword by adding five check bits, and the whole codeword goes to the array. Every read brings a 21-bit word back from the array. The block recomputes the five-bit syndrome and returns 16 data bits to the processor. The check bits never appear on the processor side.

The processor sees a simple ready/valid exchange. A write is accepted in one cycle and goes straight through to the array. A read keeps `cpu_ready` low until the data returns. When the stored word is clean, the data is returned one clock after the array answers. When a single bit had to be repaired, the data is returned one clock later than that, and a corrected-error pulse is raised. A saturating counter tallies repairs. A syndrome outside the codeword raises an uncorrectable flag, and the data is returned unmodified.

Top module: `sec_mem_ctrl`

## Requirements
- R1: An accepted write drives `mem_en`=1, `mem_we`=1, `mem_addr`=`cpu_addr` and a codeword on `mem_wdata` in the same cycle. In that codeword, bit index i holds position i+1. The check bits sit at positions 1, 2, 4, 8 and 16. The data bits 0..15 fill positions 3,5,6,7,9..15,17..21 in ascending order. Check bit 2^k is the even parity of all positions, other than itself, whose number has bit k set.
- R2: On a read whose syndrome is zero, `cpu_rvalid` is high for exactly one cycle: the cycle after the one in which `mem_rvalid` was sampled high. In that cycle `cpu_rdata` equals the stored data, and `ce_pulse` and `ue_flag` are low.
- R3: When the syndrome is 1..21 and names a data position, that bit is inverted. `cpu_rvalid` rises two cycles after the `mem_rvalid` cycle, with the repaired data and `ce_pulse` high for that one cycle.
- R4: When the syndrome names a check-bit position (1, 2, 4, 8 or 16), the returned data equals the stored data bits. The read still takes the extra cycle and still raises `ce_pulse`.
- R5: A syndrome of 22..31 returns the unmodified stored data bits one cycle after the `mem_rvalid` cycle, with `ue_flag` high, `ce_pulse` low, and `ce_count` unchanged.
- R6: From the cycle after a read is accepted until the cycle in which its `cpu_rvalid` is high, `cpu_ready` is low. A `cpu_req` presented in that window produces no `mem_en`.
- R7: `ce_count` rises by one with each `ce_pulse`, and holds once it reaches all ones (255 at the default width).
- R8: While `rst_n` is low, and after it is released, `cpu_ready`=1, `cpu_rvalid`=0, `ce_pulse`=0, `ue_flag`=0 and `ce_count`=0. A later synchronous reset clears `ce_count` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (18) | Word address |
| cpu_wdata | input | DATA_W (16) | Write data |
| cpu_ready | output | 1 | Block can take a request this cycle |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | DATA_W (16) | Read data |
| ce_pulse | output | 1 | A single-bit repair was made on this read |
| ue_flag | output | 1 | Syndrome out of range on this read |
| ce_count | output | CNT_W (8) | Saturating count of repairs |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W (18) | Array address |
| mem_wdata | output | DATA_W+CHK_W (21) | Codeword to store |
| mem_rvalid | input | 1 | Array read data valid |
| mem_rdata | input | DATA_W+CHK_W (21) | Codeword read back |

## Verification
The write outputs are combinational from the request, so the bench samples them one nanosecond after it drives the request, inside the same cycle. Read results follow a fixed count of registers after the cycle in which the bench presents `mem_rvalid`. A clean or uncorrectable read is checked at the next falling edge. For a repaired read, the bench first confirms that `cpu_rvalid` is still low at the next falling edge, then checks the data and the flags one falling edge later. The array latency is varied from zero to several cycles, which shows that the delay is counted from the array's answer and not from the request.

// File: rtl/ecc_pkg.sv
// Shared constants, state type and codeword layout helper for the ECC controller.
// Assumes 1-indexed codeword positions with check bits at powers of two.
package ecc_pkg;
    localparam int DATA_W_DEF = 16;
    localparam int CHK_W_DEF  = 5;
    localparam int ADDR_W_DEF = 18;
    localparam int CNT_W_DEF  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIX  = 2'd2
    } rd_state_t;

    // Codeword position (1-based) that holds data bit idx: the idx-th non-power-of-two.
    function automatic int data_pos(input int idx);
        int seen;
        seen = 0;
        for (int p = 1; p < 256; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) return p;
                seen++;
            end
        end
        return 0;
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// Builds the stored codeword from a data word: places the data bits, then fills each check bit with even parity.
// Assumes CHK_W is large enough that 2**CHK_W - 1 >= DATA_W + CHK_W.
module ecc_encoder #(
    parameter int DATA_W = ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = ecc_pkg::CHK_W_DEF,
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CW_W-1:0]   code_out
);
    // Scatter the data, then compute each parity group over the scattered word.
    always_comb begin
        logic [CW_W-1:0] cw;
        logic            par;
        cw = '0;
        for (int i = 0; i < DATA_W; i++) begin
            cw[ecc_pkg::data_pos(i) - 1] = data_in[i];
        end
        for (int k = 0; k < CHK_W; k++) begin
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1) par = par ^ cw[p-1];
            end
            if ((1 << k) <= CW_W) cw[(1 << k) - 1] = par;
        end
        code_out = cw;
    end
endmodule

// File: rtl/ecc_syndrome.sv
// Recomputes the parity groups of a stored codeword; a zero result means the word is consistent.
// Assumes the same position layout as ecc_encoder.
module ecc_syndrome #(
    parameter int DATA_W = ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = ecc_pkg::CHK_W_DEF,
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]  code_in,
    output logic [CHK_W-1:0] syndrome
);
    // One parity tree per syndrome bit over every position whose number has that bit set.
    always_comb begin
        for (int k = 0; k < CHK_W; k++) begin
            syndrome[k] = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> k) & 1) == 1) syndrome[k] = syndrome[k] ^ code_in[p-1];
            end
        end
    end
endmodule

// File: rtl/ecc_extract.sv
// Gathers the data bits back out of a codeword, dropping the check positions.
// Assumes the same position layout as ecc_encoder.
module ecc_extract #(
    parameter int DATA_W = ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = ecc_pkg::CHK_W_DEF,
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]   code_in,
    output logic [DATA_W-1:0] data_out
);
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_pick
            // Route data bit gi from its fixed codeword position.
            assign data_out[gi] = code_in[ecc_pkg::data_pos(gi) - 1];
        end
    endgenerate
endmodule

// File: rtl/ecc_corrector.sv
// Inverts the codeword bit named by a syndrome in 1..CW_W, then extracts the data.
// Assumes the caller only uses the result for syndromes in range; out-of-range values flip nothing.
module ecc_corrector #(
    parameter int DATA_W = ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = ecc_pkg::CHK_W_DEF,
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]   code_in,
    input  logic [CHK_W-1:0]  syndrome,
    output logic [DATA_W-1:0] data_out
);
    logic [CW_W-1:0] flip_mask;
    logic [CW_W-1:0] fixed_cw;

    // Decode the syndrome into a one-hot flip mask.
    always_comb begin
        flip_mask = '0;
        for (int p = 0; p < CW_W; p++) begin
            if (syndrome == CHK_W'(p + 1)) flip_mask[p] = 1'b1;
        end
    end

    assign fixed_cw = code_in ^ flip_mask;

    ecc_extract #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_extract (
        .code_in  (fixed_cw),
        .data_out (data_out)
    );
endmodule

// File: rtl/sec_mem_ctrl.sv
// Top level: encodes writes on the fly, checks reads, and adds one cycle only when a bit is repaired.
// Assumes the array answers each read once, with mem_rvalid, at any latency of zero or more cycles after the request.
module sec_mem_ctrl #(
    parameter int DATA_W = ecc_pkg::DATA_W_DEF,
    parameter int CHK_W  = ecc_pkg::CHK_W_DEF,
    parameter int ADDR_W = ecc_pkg::ADDR_W_DEF,
    parameter int CNT_W  = ecc_pkg::CNT_W_DEF,
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ce_pulse,
    output logic              ue_flag,
    output logic [CNT_W-1:0]  ce_count,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CW_W-1:0]   mem_wdata,
    input  logic              mem_rvalid,
    input  logic [CW_W-1:0]   mem_rdata
);
    import ecc_pkg::*;

    localparam logic [CHK_W-1:0] SYN_LAST = CHK_W'(CW_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    rd_state_t         state;
    logic [CW_W-1:0]   cw_q;
    logic [CHK_W-1:0]  syn_q;
    logic [CHK_W-1:0]  syn_raw;
    logic [DATA_W-1:0] raw_data;
    logic [DATA_W-1:0] fix_data;
    logic              syn_zero;
    logic              syn_bad;
    logic              fix_done;

    ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_in  (cpu_wdata),
        .code_out (mem_wdata)
    );

    ecc_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
        .code_in  (mem_rdata),
        .syndrome (syn_raw)
    );

    ecc_extract #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_raw (
        .code_in  (mem_rdata),
        .data_out (raw_data)
    );

    ecc_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
        .code_in  (cw_q),
        .syndrome (syn_q),
        .data_out (fix_data)
    );

    // Request path goes straight through to the array while idle.
    assign cpu_ready = (state == ST_IDLE);
    assign mem_en    = cpu_req & cpu_ready;
    assign mem_we    = mem_en & cpu_we;
    assign mem_addr  = cpu_addr;

    assign syn_zero  = (syn_raw == '0);
    assign syn_bad   = (syn_raw > SYN_LAST);
    assign fix_done  = (state == ST_FIX);

    // Read sequencer: wait for the array, finish clean reads at once, park correctable words one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
            ce_pulse   <= 1'b0;
            ue_flag    <= 1'b0;
            cw_q       <= '0;
            syn_q      <= '0;
        end else begin
            cpu_rvalid <= 1'b0;
            ce_pulse   <= 1'b0;
            ue_flag    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (mem_en && !cpu_we) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (syn_zero || syn_bad) begin
                            cpu_rvalid <= 1'b1;
                            cpu_rdata  <= raw_data;
                            ue_flag    <= syn_bad;
                            state      <= ST_IDLE;
                        end else begin
                            cw_q  <= mem_rdata;
                            syn_q <= syn_raw;
                            state <= ST_FIX;
                        end
                    end
                end
                ST_FIX: begin
                    cpu_rvalid <= 1'b1;
                    cpu_rdata  <= fix_data;
                    ce_pulse   <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Repair tally: one step per completed repair, stuck at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_count <= '0;
        end else if (fix_done && ce_count != CNT_MAX) begin
            ce_count <= ce_count + 1'b1;
        end
    end
endmodule

// File: rtl/sec_mem_ctrl_chk.sv
// Protocol checker for sec_mem_ctrl, attached by bind; observes ports only.
// Assumes the synchronous active-low reset is asserted from time zero.
module sec_mem_ctrl_chk #(
    parameter int CNT_W = ecc_pkg::CNT_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             cpu_rvalid,
    input logic             ce_pulse,
    input logic             ue_flag,
    input logic [CNT_W-1:0] ce_count,
    input logic             mem_en,
    input logic             mem_we
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r6_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !cpu_ready);

    a_r6_no_issue_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> !mem_en);

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    a_r2_valid_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> cpu_ready);

    a_r3_ce_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |-> cpu_rvalid);

    a_r5_ue_alone: assert property (@(posedge clk) disable iff (!rst_n)
        ue_flag |-> (cpu_rvalid && !ce_pulse));

    a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_pulse |-> $stable(ce_count));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse && $past(ce_count) != CNT_MAX) |-> (ce_count == $past(ce_count) + 1'b1));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_count) == CNT_MAX) |-> (ce_count == CNT_MAX));
endmodule

bind sec_mem_ctrl sec_mem_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .ce_pulse   (ce_pulse),
    .ue_flag    (ue_flag),
    .ce_count   (ce_count),
    .mem_en     (mem_en),
    .mem_we     (mem_we)
);

// File: tb/sec_mem_ctrl_tb.sv
`timescale 1ns/1ps
module sec_mem_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid, ce_pulse, ue_flag;
    logic [15:0] cpu_rdata;
    logic [7:0]  ce_count;
    logic        mem_en, mem_we;
    logic [17:0] mem_addr;
    logic [20:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [20:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    sec_mem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .ce_pulse(ce_pulse),
        .ue_flag(ue_flag), .ce_count(ce_count), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    // Data positions from R1: 3,5,6,7,9..15,17..21.
    function automatic int dpos(input int i);
        int tbl [16] = '{3,5,6,7,9,10,11,12,13,14,15,17,18,19,20,21};
        return tbl[i];
    endfunction

    // Reference encoder written from R1.
    function automatic logic [20:0] ref_code(input logic [15:0] d);
        logic [20:0] w;
        w = '0;
        foreach (d[i]) w[dpos(i) - 1] = d[i];
        for (int k = 0; k < 5; k++) begin
            logic x;
            x = 1'b0;
            for (int i = 0; i < 16; i++) if (dpos(i) & (1 << k)) x ^= d[i];
            w[(1 << k) - 1] = x;
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One read: request, wait lat cycles, answer with word, check result timing and value.
    task automatic do_read(input logic [20:0] word, input int lat, input logic [15:0] exp_d,
                           input bit fix, input bit ue, input string req);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 18'h2_0F0F;
        #1 chk({req, " issue"}, {31'd0, mem_en & ~mem_we}, 32'd1);
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R6 busy", {31'd0, cpu_ready}, 32'd0);
        repeat (lat) @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = word;
        @(negedge clk);
        mem_rvalid = 1'b0;
        if (!fix) begin
            chk({req, " valid"}, {31'd0, cpu_rvalid}, 32'd1);
            chk({req, " data"}, {16'd0, cpu_rdata}, {16'd0, exp_d});
            chk({req, " flags"}, {30'd0, ce_pulse, ue_flag}, {30'd0, 1'b0, ue});
            chk({req, " count"}, {24'd0, ce_count}, exp_cnt);
        end else begin
            chk({req, " not early"}, {31'd0, cpu_rvalid}, 32'd0);
            @(negedge clk);
            if (exp_cnt < 255) exp_cnt++;
            chk({req, " valid"}, {31'd0, cpu_rvalid}, 32'd1);
            chk({req, " data"}, {16'd0, cpu_rdata}, {16'd0, exp_d});
            chk({req, " flags"}, {30'd0, ce_pulse, ue_flag}, 32'd2);
            chk("R7 count", {24'd0, ce_count}, exp_cnt);
        end
    endtask

    task automatic t_reset;
        chk("R8 ready in reset", {31'd0, cpu_ready}, 32'd1);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R8 ready", {31'd0, cpu_ready}, 32'd1);
        chk("R8 flags", {29'd0, cpu_rvalid, ce_pulse, ue_flag}, 32'd0);
        chk("R8 count", {24'd0, ce_count}, 32'd0);
    endtask

    task automatic t_write;
        logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0001};
        foreach (pats[i]) begin
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_wdata = pats[i]; cpu_addr = 18'(i * 4099);
            #1;
            chk("R1 strobes", {30'd0, mem_en, mem_we}, 32'd3);
            chk("R1 addr", {14'd0, mem_addr}, {14'd0, 18'(i * 4099)});
            chk("R1 codeword", {11'd0, mem_wdata}, {11'd0, ref_code(pats[i])});
            @(negedge clk); cpu_req = 1'b0; cpu_we = 1'b0;
            chk("R1 ready after write", {31'd0, cpu_ready}, 32'd1);
        end
    endtask

    task automatic t_clean;
        do_read(ref_code(16'h1234), 0, 16'h1234, 0, 0, "R2 clean lat0");
        do_read(ref_code(16'hBEEF), 3, 16'hBEEF, 0, 0, "R2 clean lat3");
        @(negedge clk);
        chk("R2 single pulse", {31'd0, cpu_rvalid}, 32'd0);
    endtask

    task automatic t_data_fix;
        for (int i = 0; i < 16; i++) begin
            logic [20:0] w;
            w = ref_code(16'h5A69);
            w[dpos(i) - 1] = ~w[dpos(i) - 1];
            do_read(w, i % 3, 16'h5A69, 1, 0, "R3 data bit repair");
        end
    endtask

    task automatic t_chk_fix;
        for (int k = 0; k < 5; k++) begin
            logic [20:0] w;
            w = ref_code(16'hC0DE);
            w[(1 << k) - 1] = ~w[(1 << k) - 1];
            do_read(w, 1, 16'hC0DE, 1, 0, "R4 check bit repair");
        end
    endtask

    task automatic t_uncorr;
        logic [20:0] w;
        w = ref_code(16'h0F0F);
        w[2] = ~w[2];
        w[19] = ~w[19];
        do_read(w, 2, 16'h0F0F ^ 16'h4001, 0, 1, "R5 syndrome 23");
    endtask

    task automatic t_busy;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0;
        @(negedge clk);
        cpu_we = 1'b1; cpu_wdata = 16'hFFFF;
        #1 chk("R6 ignored while busy", {31'd0, mem_en}, 32'd0);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk("R6 still busy", {31'd0, cpu_ready}, 32'd0);
        mem_rvalid = 1'b1; mem_rdata = ref_code(16'h7777);
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R6 read result", {16'd0, cpu_rdata}, 32'h7777);
        chk("R6 ready at valid", {31'd0, cpu_ready}, 32'd1);
    endtask

    task automatic t_saturate;
        logic [20:0] w;
        w = ref_code(16'h2468);
        w[10] = ~w[10];
        for (int i = 0; i < 260; i++) do_read(w, 0, 16'h2468, 1, 0, "R7 saturation");
        chk("R7 stuck at max", {24'd0, ce_count}, 32'd255);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        exp_cnt = 0;
        @(negedge clk);
        chk("R8 count cleared", {24'd0, ce_count}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write();
        t_clean();
        t_data_fix();
        t_chk_fix();
        t_uncorr();
        t_busy();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule